// File: doc/BRIEF.md
# Serial-Loaded Switch Enable Register

This block is the digital control core for a bank of independent on/off switches that are programmed over a three-wire serial link. The link has an active-low frame strobe, a serial clock and a data line. While the frame strobe is low, each falling edge of the serial clock shifts the data bit into a shift register. Bits enter the register most significant bit first. When the frame strobe rises, the register contents are copied into the switch-enable output. A frame may carry any number of clocks, and only the last eight bits take effect.

The bit pushed out of the top of the register is presented on an open-drain serial output at the following rising edge of the serial clock. Because of this, the output repeats the input delayed by eight clocks. This serves both for reading back the register and for chaining several blocks, using eight clocks per block in each frame. The three serial pins, and an active-low clear pin, are sampled by a faster system clock through two-flop synchronizers. All edges are detected from these synchronized samples, so the system clock must run at least four times faster than the serial clock. The open-drain output is modelled as a drive enable plus a data value that is always low.

Top module: `ssc_switch_ctl`

## Requirements
- R1: After the system reset `rst`, `sw_en` is all zeros, the shift register is all zeros, and the serial output drives the line low (`sdo_oe` = 1).
- R2: While `frm_n` is low, `sdi` is captured on every falling edge of `sck`. After eight clocks, the first bit sent sits in `sw_en[7]` (switch 8) and the last bit sent sits in `sw_en[0]` (switch 1).
- R3: A 1 in `sw_en[i]` turns switch i+1 on and a 0 turns it off. Every one of the 256 patterns can be loaded and reads back exactly.
- R4: A frame with fewer than eight clocks shifts its bits into the low end of the register. The older bits move up by the same count, so the register holds the last eight bits ever shifted in.
- R5: A frame with more than eight clocks leaves only its last eight bits in the register.
- R6: `sw_en` changes only when `frm_n` rises. During a frame it keeps its previous value.
- R7: While `frm_n` is high, activity on `sck` and `sdi` changes neither the register nor the serial output.
- R8: After each rising edge of `sck` inside a frame, the serial output line carries the bit that the preceding falling edge pushed out of bit 7. The line therefore repeats `sdi` delayed by eight clocks.
- R9: The output is open-drain. `sdo_o` is always 0, `sdo_oe` is 1 to pull the line low for a 0 bit, and `sdo_oe` is 0 to release the line for a 1 bit.
- R10: Holding `clr_n` low clears the shift register, clears `sw_en`, and makes the serial output drive the line low.
- R11: An `sck` edge that reaches the synchronized samples in the same cycle as the `frm_n` rising edge is ignored. The commit uses the register value from before that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples the serial pins |
| rst | input | 1 | Synchronous active-high system reset |
| clr_n | input | 1 | Active-low clear pin, synchronized |
| frm_n | input | 1 | Active-low frame strobe |
| sck | input | 1 | Serial clock; data is shifted in on its falling edge |
| sdi | input | 1 | Serial data in, most significant bit first |
| sw_en | output | N | Switch enables; bit i drives switch i+1 |
| sdo_oe | output | 1 | Open-drain drive enable for the serial output |
| sdo_o | output | 1 | Open-drain data value, always 0 |

## Verification
The bench loads every one of the 256 eight-bit patterns. This separates a bit-order reversal or a stuck enable bit from a correct load. While these patterns are clocked, every serial-output bit is compared with a model of the eight-clock delay, which also catches an off-by-one in the readback path. Short frames, long frames and sixteen-clock frames show whether older bits are kept or dropped correctly. Noise sent while the frame strobe is high, a clock edge that coincides with the end of a frame, and the clear pin are each followed by an empty frame. The empty frame exposes the internal register at `sw_en`.

// File: rtl/ssc_pkg.sv
package ssc_pkg;
  // Events derived from one synchronized sample of the serial pins
  typedef struct packed {
    logic sclk_fall;
    logic sclk_rise;
    logic frame_end;
    logic active;
  } ssc_evt_t;

  localparam int SSC_MIN_SYNC_DEPTH = 2;
endpackage

// File: rtl/ssc_sync.sv
module ssc_sync #(
  parameter int           W       = 1,
  parameter int           DEPTH   = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [DEPTH-1:0][W-1:0] stg;

  always_ff @(posedge clk) begin
    if (rst) stg <= {DEPTH{RST_VAL}};
    else     stg <= {stg[DEPTH-2:0], d};
  end

  assign q = stg[DEPTH-1];
endmodule

// File: rtl/ssc_edge.sv
module ssc_edge
  import ssc_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     sclk_s,
  input  logic     frm_s,
  output ssc_evt_t evt
);
  logic sclk_q;
  logic frm_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sclk_q <= 1'b1;
      frm_q  <= 1'b1;
    end else begin
      sclk_q <= sclk_s;
      frm_q  <= frm_s;
    end
  end

  always_comb begin
    evt.sclk_fall = sclk_q & ~sclk_s;
    evt.sclk_rise = ~sclk_q & sclk_s;
    evt.frame_end = ~frm_q & frm_s;
    evt.active    = ~frm_s;
  end
endmodule

// File: rtl/ssc_shift.sv
module ssc_shift
  import ssc_pkg::*;
#(
  parameter int N = 8
) (
  input  logic         clk,
  input  logic         kill,
  input  ssc_evt_t     evt,
  input  logic         din_s,
  output logic [N-1:0] shreg,
  output logic [N-1:0] sw_en,
  output logic         sdo_low
);
  logic eject_q;

  always_ff @(posedge clk) begin
    if (kill) begin
      shreg   <= '0;
      sw_en   <= '0;
      eject_q <= 1'b0;
      sdo_low <= 1'b1;
    end else begin
      if (evt.active && evt.sclk_fall) begin
        shreg   <= {shreg[N-2:0], din_s};
        eject_q <= shreg[N-1];
      end
      if (evt.active && evt.sclk_rise)
        sdo_low <= ~eject_q;
      if (evt.frame_end)
        sw_en <= shreg;
    end
  end
endmodule

// File: rtl/ssc_switch_ctl.sv
module ssc_switch_ctl
  import ssc_pkg::*;
#(
  parameter int N          = 8,
  parameter int SYNC_DEPTH = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr_n,
  input  logic         frm_n,
  input  logic         sck,
  input  logic         sdi,
  output logic [N-1:0] sw_en,
  output logic         sdo_oe,
  output logic         sdo_o
);
  localparam int DEPTH = (SYNC_DEPTH < SSC_MIN_SYNC_DEPTH) ? SSC_MIN_SYNC_DEPTH : SYNC_DEPTH;
  localparam int PIN_W = 3;

  logic [PIN_W-1:0] pins_s;
  logic             clr_s;
  logic             kill;
  ssc_evt_t         evt;
  logic [N-1:0]     shreg;

  ssc_sync #(.W(PIN_W), .DEPTH(DEPTH), .RST_VAL(3'b110)) u_pin_sync (
    .clk(clk), .rst(rst), .d({frm_n, sck, sdi}), .q(pins_s)
  );

  ssc_sync #(.W(1), .DEPTH(DEPTH), .RST_VAL(1'b1)) u_clr_sync (
    .clk(clk), .rst(rst), .d(clr_n), .q(clr_s)
  );

  assign kill = rst | ~clr_s;

  ssc_edge u_edge (
    .clk(clk), .rst(rst), .sclk_s(pins_s[1]), .frm_s(pins_s[2]), .evt(evt)
  );

  ssc_shift #(.N(N)) u_shift (
    .clk(clk), .kill(kill), .evt(evt), .din_s(pins_s[0]),
    .shreg(shreg), .sw_en(sw_en), .sdo_low(sdo_oe)
  );

  assign sdo_o = 1'b0;
endmodule

// File: rtl/ssc_switch_ctl_chk.sv
module ssc_switch_ctl_chk
  import ssc_pkg::*;
#(
  parameter int N = 8
) (
  input logic         clk,
  input logic         rst,
  input logic         kill,
  input ssc_evt_t     evt,
  input logic [N-1:0] shreg,
  input logic [N-1:0] sw_en,
  input logic         sdo_oe
);
  // R1 / R10: a clear empties both registers and pulls the line low
  p_clear_r10: assert property (@(posedge clk) disable iff (rst)
    kill |=> (sw_en == '0 && shreg == '0 && sdo_oe));

  // R6: enables hold outside the frame end
  p_hold_r6: assert property (@(posedge clk) disable iff (rst)
    (!kill && !evt.frame_end) |=> $stable(sw_en));

  // R6: commit copies the register
  p_commit_r6: assert property (@(posedge clk) disable iff (rst)
    (!kill && evt.frame_end) |=> (sw_en == $past(shreg)));

  // R7: no frame, no shift
  p_idle_r7: assert property (@(posedge clk) disable iff (rst)
    (!kill && !evt.active) |=> $stable(shreg));

  // R2: a shift moves every bit one place up
  p_shift_r2: assert property (@(posedge clk) disable iff (rst)
    (!kill && evt.active && evt.sclk_fall) |=> (shreg[N-1:1] == $past(shreg[N-2:0])));

  // R11: clock edge at the frame end leaves register and output alone
  p_coincide_r11: assert property (@(posedge clk) disable iff (rst)
    (!kill && evt.frame_end && (evt.sclk_fall || evt.sclk_rise))
      |=> ($stable(shreg) && $stable(sdo_oe)));
endmodule

bind ssc_switch_ctl ssc_switch_ctl_chk #(.N(N)) u_chk (
  .clk(clk), .rst(rst), .kill(kill), .evt(evt),
  .shreg(shreg), .sw_en(sw_en), .sdo_oe(sdo_oe)
);

// File: tb/sim_ssc_switch_ctl.sv
module sim_ssc_switch_ctl;
  localparam int N = 8;

  logic clk = 1'b0;
  logic rst, clr_n, frm_n, sck, sdi;
  logic [N-1:0] sw_en;
  logic sdo_oe, sdo_o;
  logic sdo_line;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [N-1:0] m_sh = '0;
  logic [N-1:0] m_sw = '0;
  logic         m_ej = 1'b0;

  always #5 clk = ~clk;

  ssc_switch_ctl #(.N(N), .SYNC_DEPTH(2)) u0 (
    .clk(clk), .rst(rst), .clr_n(clr_n), .frm_n(frm_n), .sck(sck), .sdi(sdi),
    .sw_en(sw_en), .sdo_oe(sdo_oe), .sdo_o(sdo_o)
  );

  assign sdo_line = sdo_oe ? sdo_o : 1'b1;

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk8(input string tag, input logic [N-1:0] act, input logic [N-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic chk1(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %b expected %b", tag, act, exp);
    end
  endtask

  // one serial clock inside a frame; the model shifts and ejects
  task automatic clock_bit(input logic b);
    sdi = b;
    step(3);
    sck = 1'b0;
    step(6);
    m_ej = m_sh[N-1];
    m_sh = {m_sh[N-2:0], b};
    sck = 1'b1;
    step(6);
    chk1("R8 sdo line", sdo_line, m_ej);
    chk1("R9 sdo data", sdo_o, 1'b0);
  endtask

  task automatic frame(input logic [31:0] w, input int n, input string tag);
    frm_n = 1'b0;
    step(6);
    for (int i = n - 1; i >= 0; i--) clock_bit(w[i]);
    chk8("R6 hold in frame", sw_en, m_sw);
    frm_n = 1'b1;
    step(6);
    m_sw = m_sh;
    chk8(tag, sw_en, m_sw);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; clr_n = 1'b1; frm_n = 1'b1; sck = 1'b1; sdi = 1'b0;
    step(4);
    rst = 1'b0;
    step(2);
    chk8("R1 reset sw_en", sw_en, '0);
    chk1("R1 reset line low", sdo_line, 1'b0);
    frame(32'h0, 0, "R1 reset shift reg");

    frame(32'h80, 8, "R2 first bit to switch 8");
    frame(32'h01, 8, "R2 last bit to switch 1");

    // R7: noise while the strobe is high
    frame(32'h3C, 8, "R2 load before idle noise");
    for (int k = 0; k < 10; k++) begin
      sdi = k[0]; step(3); sck = 1'b0; step(6); sck = 1'b1; step(6);
    end
    chk8("R7 idle sw_en", sw_en, m_sw);
    chk1("R7 idle line", sdo_line, m_ej);
    frame(32'h0, 0, "R7 idle shift reg");

    for (int v = 0; v < 256; v++) frame(v, 8, "R3 pattern");

    frame(32'h5, 3, "R4 short frame");
    frame(32'h1ABC, 13, "R5 long frame");
    frame(32'hC35A, 16, "R8 sixteen clock frame");

    // R11: clock edge at the same time as the strobe rises
    frm_n = 1'b0;
    step(6);
    for (int i = 7; i >= 0; i--) clock_bit(8'hA5 >> i);
    sdi = 1'b1;
    step(3);
    sck = 1'b0;
    frm_n = 1'b1;
    step(6);
    m_sw = m_sh;
    chk8("R11 commit before edge", sw_en, m_sw);
    chk1("R11 line unchanged", sdo_line, m_ej);
    sck = 1'b1;
    step(6);
    frame(32'h0, 0, "R11 shift reg unchanged");

    // R10: clear pin
    frame(32'hFF, 8, "R3 load before clear");
    clr_n = 1'b0;
    step(6);
    m_sh = '0; m_sw = '0; m_ej = 1'b0;
    chk8("R10 clear sw_en", sw_en, '0);
    chk1("R10 clear line low", sdo_line, 1'b0);
    clr_n = 1'b1;
    step(6);
    frame(32'h0, 0, "R10 clear shift reg");

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule